// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit general-purpose timer for a peripheral subsystem. A processor programs it through a small register window that is addressed by byte. The count is driven by the system clock through a programmable prescaler. The prescaler divisor comes from the high byte of the control register. One clock-source setting adds a further fixed divide-by-16, and the other two settings stop the count altogether.

Each time the prescaler produces a tick, the counter is compared with the reference register. A tick that finds them equal latches a sticky reference event. Software clears that event by writing a one to its bit. In restart mode the same tick also sends the counter back to zero. In free-run mode the counter keeps climbing and wraps after all ones. The interrupt line is a level output: it is high while the event is latched and the interrupt enable in the control register is set. Turning the timer off through the control register clears the reference register and holds the counter and prescaler at zero.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, every register reads zero and irq is low.
- R2: The register window uses these byte offsets: control at 0x00, reference at 0x04, capture at 0x08, counter at 0x0C and event at 0x11. The event register holds bit 1 for the reference event and bit 0 for the capture event. A read from any other offset returns zero, and a write to any other offset changes nothing.
- R3: Control bits [2:1] select the clock source. With value 1, one tick occurs every control[15:8]+1 clock cycles. With value 2, one tick occurs every (control[15:8]+1)*16 clock cycles. Values 0 and 3 give no ticks. With value 1 or 2, enabling the timer makes the first tick fall that many cycles after the enabling write.
- R4: While control bit 0 (enable) is 0, the counter and the prescaler are held at zero.
- R5: With control bit 3 clear (free run), each tick adds one to the counter, which wraps from 0xFFFF to 0x0000.
- R6: With control bit 3 set (restart), a tick that finds the counter equal to the reference value returns the counter to zero.
- R7: A tick that finds the counter equal to the reference value sets event bit 1 in either mode. The bit stays set until software clears it.
- R8: A write to the event register clears each bit written as one and leaves every bit written as zero unchanged. If a hardware set lands in the same cycle as the clear, the set wins.
- R9: irq is high exactly when control bit 4 and event bit 1 are both set.
- R10: A control write that changes bit 0 from 1 to 0 clears the reference register and then stores the written value. A control write while bit 0 is already 0 leaves the reference register unchanged.
- R11: A write to the counter loads the written value. The load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register window |
| addr | input | 5 | Byte offset into the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the offset on addr (combinational) |
| irq | output | 1 | Level interrupt for the reference event |

## Verification
The hardest condition to reach from the ports is a reference match on exactly the right tick when the prescaler is running at a large divisor. This is hard because the event depends on how many ticks have elapsed, not on how many cycles. The bench disables the timer before each trial and enables it again with a single control write. That write gives a known cycle zero, so the expected tick count is the number of elapsed cycles divided by the divisor. A random mix of divisors, slow-source selection, reference values and modes then places the sample point before, on and after the matching tick. Directed cases cover the divisor edge (31 against 32 cycles at the slow source), a counter wrap, and clearing the event register while the event is held.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register byte offsets (the event byte sits at an odd offset)
    localparam int OFS_MODE = 'h00;
    localparam int OFS_REF  = 'h04;
    localparam int OFS_CAP  = 'h08;
    localparam int OFS_CNT  = 'h0C;
    localparam int OFS_EVT  = 'h11;

    // control register fields
    localparam int MB_EN      = 0;
    localparam int MB_SRC_LO  = 1;
    localparam int MB_RESTART = 3;
    localparam int MB_IEN     = 4;
    localparam int MB_PSC_LO  = 8;

    // event register bits
    localparam int EB_CAP = 0;
    localparam int EB_REF = 1;

    typedef enum logic [1:0] {
        SRC_NONE_A   = 2'd0,
        SRC_SYS      = 2'd1,
        SRC_SYS_SLOW = 2'd2,
        SRC_NONE_B   = 2'd3
    } clk_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick,
    output logic [PRE_W-1:0] pres_val
);
    logic [PRE_W-1:0] pres_d, pres_q;

    always_comb begin
        // >= keeps the divider sane if the divisor shrinks mid-count
        tick = run && (pres_q >= div_m1);
        if (!run)
            pres_d = '0;
        else if (tick)
            pres_d = '0;
        else
            pres_d = pres_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pres_q <= '0;
        else        pres_q <= pres_d;
    end

    assign pres_val = pres_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] refv,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ref_hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ref_hit = en && tick && (cnt_q == refv);
        if (!en)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (tick)
            cnt_d = (ref_hit && restart) ? '0 : cnt_q + CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_val = cnt_q;
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PSC_W      = 8,
    parameter int SLOW_SHIFT = 4,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    localparam int PRE_W = PSC_W + SLOW_SHIFT + 1;

    typedef struct packed {
        logic [CNT_W-1:0] mode;
        logic [CNT_W-1:0] refv;
        logic [CNT_W-1:0] cap;
        logic [1:0]       evt;
    } regs_t;

    regs_t r_d, r_q;

    logic             sel_mode, sel_ref, sel_cap, sel_cnt, sel_evt;
    logic             run, tick, ref_hit;
    logic [PRE_W-1:0] div_base, div_m1, pres_val;
    logic [CNT_W-1:0] cnt_val, mode_q, ref_q;
    logic [1:0]       evt_q;
    clk_src_e         src;

    assign sel_mode = (addr == ADDR_W'(OFS_MODE));
    assign sel_ref  = (addr == ADDR_W'(OFS_REF));
    assign sel_cap  = (addr == ADDR_W'(OFS_CAP));
    assign sel_cnt  = (addr == ADDR_W'(OFS_CNT));
    assign sel_evt  = (addr == ADDR_W'(OFS_EVT));

    assign src = clk_src_e'(r_q.mode[MB_SRC_LO +: 2]);
    assign run = r_q.mode[MB_EN] && (src == SRC_SYS || src == SRC_SYS_SLOW);

    assign div_base = PRE_W'(r_q.mode[MB_PSC_LO +: PSC_W]) + PRE_W'(1);
    generate
        if (SLOW_SHIFT > 0) begin : g_slow
            assign div_m1 = (src == SRC_SYS_SLOW) ? (div_base << SLOW_SHIFT) - PRE_W'(1)
                                                  : div_base - PRE_W'(1);
        end else begin : g_noslow
            assign div_m1 = div_base - PRE_W'(1);
        end
    endgenerate

    tmr_prescaler #(.PRE_W(PRE_W)) u_pres (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_m1   (div_m1),
        .tick     (tick),
        .pres_val (pres_val)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (r_q.mode[MB_EN]),
        .tick     (tick),
        .restart  (r_q.mode[MB_RESTART]),
        .refv     (r_q.refv),
        .load     (wr_en && sel_cnt),
        .load_val (wdata),
        .cnt_val  (cnt_val),
        .ref_hit  (ref_hit)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && sel_mode) begin
            if (r_q.mode[MB_EN] && !wdata[MB_EN])
                r_d.refv = '0;
            r_d.mode = wdata;
        end
        if (wr_en && sel_ref)
            r_d.refv = wdata;
        if (wr_en && sel_cap)
            r_d.cap = wdata;
        if (wr_en && sel_evt)
            r_d.evt = r_q.evt & ~wdata[1:0];
        // hardware set takes precedence over a same-cycle clear
        if (ref_hit)
            r_d.evt[EB_REF] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (sel_mode)     rdata = r_q.mode;
        else if (sel_ref) rdata = r_q.refv;
        else if (sel_cap) rdata = r_q.cap;
        else if (sel_cnt) rdata = cnt_val;
        else if (sel_evt) rdata = CNT_W'(r_q.evt);
    end

    assign irq    = r_q.mode[MB_IEN] && r_q.evt[EB_REF];
    assign mode_q = r_q.mode;
    assign ref_q  = r_q.refv;
    assign evt_q  = r_q.evt;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 13,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic              irq,
    input logic              tick,
    input logic              ref_hit,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [PRE_W-1:0]  pres_val,
    input logic [CNT_W-1:0]  mode_q,
    input logic [CNT_W-1:0]  ref_q,
    input logic [1:0]        evt_q
);
    logic cnt_load, evt_clr_ref;
    assign cnt_load    = wr_en && (addr == ADDR_W'(OFS_CNT));
    assign evt_clr_ref = wr_en && (addr == ADDR_W'(OFS_EVT)) && wdata[EB_REF];

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MB_EN] |=> (cnt_val == '0 && pres_val == '0));

    // R3
    no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2:1] == 2'd0 || mode_q[2:1] == 2'd3) |-> !tick);

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MB_EN] && tick && !cnt_load && !(mode_q[MB_RESTART] && cnt_val == ref_q))
        |=> cnt_val == CNT_W'($past(cnt_val) + 1'b1));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MB_RESTART] && ref_hit && !cnt_load) |=> cnt_val == '0);

    // R7
    evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[EB_REF] && !evt_clr_ref) |=> evt_q[EB_REF]);

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ref_hit) || $past(wr_en)));
endmodule

bind refcmp_timer tmr_chk #(
    .CNT_W  (CNT_W),
    .PRE_W  (PSC_W + SLOW_SHIFT + 1),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .tick     (tick),
    .ref_hit  (ref_hit),
    .cnt_val  (cnt_val),
    .pres_val (pres_val),
    .mode_q   (mode_q),
    .ref_q    (ref_q),
    .evt_q    (evt_q)
);

// File: tb/tb_refcmp_timer.sv
`timescale 1ns/1ps
module tb_refcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    refcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_cnt(int m, int div, int refv, bit rs);
        int t = m / div;
        if (rs) return t % (refv + 1);
        return t & 'hFFFF;
    endfunction

    function automatic bit exp_evt(int m, int div, int refv);
        return (m / div) >= refv + 1;
    endfunction

    initial begin
        #4_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(5'h00, v); chk("R1 mode", v, 16'h0);
        rd(5'h04, v); chk("R1 ref", v, 16'h0);
        rd(5'h0C, v); chk("R1 count", v, 16'h0);
        rd(5'h11, v); chk("R1 event", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R2 capture register and unmapped offsets
        wr(5'h08, 16'hABCD);
        rd(5'h08, v); chk("R2 capture rw", v, 16'hABCD);
        wr(5'h14, 16'hFFFF);
        rd(5'h14, v); chk("R2 unmapped read", v, 16'h0);
        rd(5'h00, v); chk("R2 unmapped write mode", v, 16'h0);
        rd(5'h10, v); chk("R2 offset 0x10 read", v, 16'h0);

        // R4 disabled: no counting
        wr(5'h00, 16'h0002);
        idle(20);
        rd(5'h0C, v); chk("R4 disabled count", v, 16'h0);

        // R10 write while disabled keeps reference
        wr(5'h04, 16'h0055);
        wr(5'h00, 16'h0000);
        rd(5'h04, v); chk("R10 ref kept", v, 16'h0055);

        // R3 source 0 and 3 do not count
        wr(5'h00, 16'h0001);
        idle(20);
        rd(5'h0C, v); chk("R3 src0 no count", v, 16'h0);
        wr(5'h00, 16'h0007);
        idle(20);
        rd(5'h0C, v); chk("R3 src3 no count", v, 16'h0);
        wr(5'h00, 16'h0000);
        idle(2);

        // R3 divisor 5 on system clock
        wr(5'h04, 16'h00FF);
        wr(5'h00, 16'h0403);
        idle(23);
        rd(5'h0C, v); chk("R3 div5 count", v, 16'd4);
        wr(5'h00, 16'h0000);
        idle(2);
        // R3 slow source, divisor 2*16 = 32: edge at 31 and 32 cycles
        wr(5'h04, 16'h00FF);
        wr(5'h00, 16'h0105);
        idle(31);
        rd(5'h0C, v); chk("R3 slow 31 cycles", v, 16'd0);
        idle(1);
        rd(5'h0C, v); chk("R3 slow 32 cycles", v, 16'd1);
        wr(5'h00, 16'h0000);
        idle(2);

        // R11 counter load and R5 wrap
        wr(5'h04, 16'h8000);
        wr(5'h00, 16'h0003);
        wr(5'h0C, 16'h0100);
        idle(5);
        rd(5'h0C, v); chk("R11 load then count", v, 16'h0105);
        wr(5'h0C, 16'hFFFE);
        idle(3);
        rd(5'h0C, v); chk("R5 wrap", v, 16'h0001);
        wr(5'h00, 16'h0000);
        idle(2);
        wr(5'h11, 16'h0003);

        // R6 restart, R7 event, R9 irq gating
        wr(5'h04, 16'h0003);
        wr(5'h00, 16'h000B);
        idle(4);
        rd(5'h0C, v); chk("R6 restart to zero", v, 16'd0);
        rd(5'h11, v); chk("R7 event set", v, 16'h0002);
        chk("R9 irq masked", {15'b0, irq}, 16'h0);
        idle(3);
        rd(5'h0C, v); chk("R6 second period", v, 16'd3);
        wr(5'h00, 16'h001B);
        chk("R9 irq on", {15'b0, irq}, 16'h1);

        // R10 turn-off clears ref, stores new value
        wr(5'h00, 16'h0010);
        rd(5'h00, v); chk("R10 mode stored", v, 16'h0010);
        rd(5'h04, v); chk("R10 ref cleared", v, 16'h0);
        idle(2);
        rd(5'h0C, v); chk("R4 count held off", v, 16'h0);
        rd(5'h11, v); chk("R7 event sticky", v, 16'h0002);

        // R8 write-one-to-clear
        wr(5'h11, 16'h0001);
        rd(5'h11, v); chk("R8 zero bit keeps event", v, 16'h0002);
        chk("R9 irq still high", {15'b0, irq}, 16'h1);
        wr(5'h11, 16'h0002);
        rd(5'h11, v); chk("R8 clear event", v, 16'h0);
        chk("R9 irq low", {15'b0, irq}, 16'h0);

        // random trials
        for (int i = 0; i < 24; i++) begin
            int psc  = $urandom_range(0, 3);
            int slow = $urandom_range(0, 1);
            int rs   = $urandom_range(0, 1);
            int ien  = $urandom_range(0, 1);
            int refv = $urandom_range(0, 40);
            int m    = $urandom_range(0, 300);
            int div  = (psc + 1) * (slow ? 16 : 1);
            logic [15:0] md;
            bit e;
            md = {8'(psc), 3'b0, 1'(ien), 1'(rs), (slow ? 2'd2 : 2'd1), 1'b1};
            wr(5'h00, 16'h0000);
            wr(5'h11, 16'h0003);
            wr(5'h04, 16'(refv));
            wr(5'h00, md);
            idle(m);
            e = exp_evt(m, div, refv);
            rd(5'h0C, v); chk("R3/R5/R6 random count", v, 16'(exp_cnt(m, div, refv, rs[0])));
            rd(5'h11, v); chk("R7 random event", v, {14'b0, e, 1'b0});
            chk("R9 random irq", {15'b0, irq}, {15'b0, e & ien[0]});
        end

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule